// File: doc/BRIEF.md
# Prescaled Match Timer

This block is a free-running up-counter, by default 32 bits wide, that advances once every (limit + 1) clocks of its own clock, where the limit sits in a prescale register. A set of match channels, two by default, each hold a compare value and three action bits. When the counter equals a channel's compare value at an increment point, the channel raises its flag. Depending on its action bits, the channel can also drive the interrupt output, load the counter with zero instead of advancing it, or clear the run bit.

Software reaches the block through a simple word-wide register port with a write strobe and a combinational read. The same counter serves two uses. With no actions armed it is a wrapping time base for a clock source, and its value is also offered directly on `count_o`. With compare value 1 and all three actions armed on one channel it becomes a one-shot event timer. The prescale limit then sets the delay, and the counter is left stopped at zero.

Top module: `evt_match_timer`

## Requirements
- R1: After reset the counter and prescale counter are 0, the run and hold bits are 0, all flags are clear, `irq_o` is low, and every register reads back 0.
- R2: The control register at address 0x0 holds run in bit 0 and hold in bit 1. While run is 0 the counter keeps its value, so writing 0 to address 0x0 stops counting.
- R3: While the hold bit is 1, the counter and the prescale counter stay at 0 whatever the run bit is. Counting resumes from 0 once hold is written back to 0.
- R4: With the prescale limit at address 0x1 set to P, a running counter advances once every P+1 clocks. P = 0 advances it on every clock. The prescale counter reads at address 0x5 and the counter at address 0x3.
- R5: With no actions armed, the counter wraps from its all-ones value to 0 and keeps running.
- R6: Channel i's compare value lives at address 0x8+i. When the counter equals it at an increment point, bit i of the flag register at address 0x2 is 1 from the following clock, whatever the channel's actions are.
- R7: The action register at address 0x4 gives channel i three bits: bit 3i enables its interrupt, bit 3i+1 restarts the counter, and bit 3i+2 halts it. On a match with restart armed, the counter loads 0 instead of advancing.
- R8: On a match with halt armed, the run bit reads 0 from the next clock. That increment still takes effect, and the counter then keeps its value.
- R9: `irq_o` is a level that is high exactly while some flag i is set and interrupt bit 3i is set. A set flag with its interrupt bit off leaves `irq_o` low.
- R10: Writing 1 to flag bit i clears it, and writing 0 leaves it. If a match of channel i falls in the same clock as a clear of flag i, the flag stays set.
- R11: If a write to the control register falls in the same clock as a halting match, the written run value is the one kept.
- R12: Writes to the counter address 0x3 are ignored.
- R13: In one-shot use (compare value 1, all three actions of the channel armed, prescale P), `irq_o` rises 2(P+1) clocks after the start write takes effect. The counter is then 0 and stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr_i | input | 4 | Register address for reads and writes |
| bus_we_i | input | 1 | Write strobe, one write per high clock |
| bus_wdata_i | input | BUS_W | Write data |
| bus_rdata_o | output | BUS_W | Combinational read data for bus_addr_i |
| irq_o | output | 1 | Level interrupt |
| count_o | output | CNT_W | Current counter value |

## Verification
Two pairs of functions can collide in a single clock, and both collisions are provoked on purpose. In the first, a match sets a flag while software clears that same flag. In the second, a halting match clears the run bit while software writes the control register. The bench starts the counter at a known clock, counts whole clocks to the match cycle, and issues the write so that it lands on exactly that edge. It then judges the outcome from the flag readback, `irq_o`, the run bit and the counter a few clocks later: the flag must stay set, and the written run value must hold.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  localparam int ADDR_W   = 4;
  localparam int ACT_BITS = 3;

  localparam logic [ADDR_W-1:0] ADR_CTRL   = 4'h0;
  localparam logic [ADDR_W-1:0] ADR_PRE    = 4'h1;
  localparam logic [ADDR_W-1:0] ADR_FLAGS  = 4'h2;
  localparam logic [ADDR_W-1:0] ADR_COUNT  = 4'h3;
  localparam logic [ADDR_W-1:0] ADR_ACTS   = 4'h4;
  localparam logic [ADDR_W-1:0] ADR_PSCNT  = 4'h5;
  localparam logic [ADDR_W-1:0] ADR_MATCH0 = 4'h8;

  localparam int MAX_MATCH = 8;

  // per-channel match actions, bit 0 = interrupt enable
  typedef struct packed {
    logic halt;
    logic restart;
    logic irq_en;
  } act_t;

endpackage

// File: rtl/evt_timer_rst_sync.sv
module evt_timer_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_no = sync_q;

endmodule

// File: rtl/evt_timer_prescaler.sv
module evt_timer_prescaler #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         clear_i,
  input  logic [W-1:0] limit_i,
  output logic         tick_o,
  output logic [W-1:0] pscnt_o
);

  logic [W-1:0] pscnt_q;
  logic [W-1:0] pscnt_d;
  logic         pscnt_en;
  logic         tick;

  // a limit lowered below the running count still ends the period at once
  always_comb begin
    tick     = run_i && !clear_i && (pscnt_q >= limit_i);
    pscnt_en = clear_i || run_i;
    pscnt_d  = pscnt_q;
    if (clear_i) begin
      pscnt_d = '0;
    end else if (tick) begin
      pscnt_d = '0;
    end else begin
      pscnt_d = pscnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pscnt_q <= '0;
    end else if (pscnt_en) begin
      pscnt_q <= pscnt_d;
    end
  end

  assign tick_o  = tick;
  assign pscnt_o = pscnt_q;

endmodule

// File: rtl/evt_timer_match_unit.sv
module evt_timer_match_unit
  import evt_timer_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         val_we_i,
  input  logic [W-1:0] val_wdata_i,
  input  logic         act_we_i,
  input  act_t         act_wdata_i,
  input  logic         flag_clr_i,
  input  logic [W-1:0] count_i,
  input  logic         tick_i,
  output logic         hit_o,
  output logic         flag_o,
  output logic [W-1:0] val_o,
  output act_t         act_o
);

  logic [W-1:0] val_q;
  act_t         act_q;
  logic         flag_q;
  logic         flag_d;
  logic         flag_en;
  logic         hit;

  always_comb begin
    hit     = tick_i && (count_i == val_q);
    flag_en = hit || flag_clr_i;
    flag_d  = flag_q;
    // a new match outranks a same-cycle clear so no event is lost
    if (hit) begin
      flag_d = 1'b1;
    end else if (flag_clr_i) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
    end else if (val_we_i) begin
      val_q <= val_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
    end else if (act_we_i) begin
      act_q <= act_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign hit_o  = hit;
  assign flag_o = flag_q;
  assign val_o  = val_q;
  assign act_o  = act_q;

endmodule

// File: rtl/evt_match_timer.sv
module evt_match_timer
  import evt_timer_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int BUS_W     = 32,
  parameter int NUM_MATCH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        bus_addr_i,
  input  logic              bus_we_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o,
  output logic              irq_o,
  output logic [CNT_W-1:0]  count_o
);

  localparam int ACT_W = ACT_BITS * NUM_MATCH;

  logic rst_sync_n;

  logic ctrl_we;
  logic pre_we;
  logic flags_we;
  logic acts_we;

  logic run_q;
  logic run_d;
  logic hold_q;
  logic hold_d;
  logic ctrl_en;

  logic [CNT_W-1:0] pre_q;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_d;
  logic             count_en;
  logic [CNT_W-1:0] pscnt;
  logic             tick;

  logic [NUM_MATCH-1:0] hit_vec;
  logic [NUM_MATCH-1:0] flag_vec;
  logic [NUM_MATCH-1:0] val_we;
  logic [CNT_W-1:0]     mval [NUM_MATCH];
  act_t                 acts [NUM_MATCH];
  logic [ACT_W-1:0]     act_flat;

  logic any_halt;
  logic any_restart;
  logic irq;

  evt_timer_rst_sync rst_sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  // write decode
  always_comb begin
    ctrl_we  = bus_we_i && (bus_addr_i == ADR_CTRL);
    pre_we   = bus_we_i && (bus_addr_i == ADR_PRE);
    flags_we = bus_we_i && (bus_addr_i == ADR_FLAGS);
    acts_we  = bus_we_i && (bus_addr_i == ADR_ACTS);
  end

  evt_timer_prescaler #(.W(CNT_W)) pre_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .run_i   (run_q),
    .clear_i (hold_q),
    .limit_i (pre_q),
    .tick_o  (tick),
    .pscnt_o (pscnt)
  );

  for (genvar g = 0; g < NUM_MATCH; g++) begin : g_chan
    assign val_we[g] = bus_we_i && (bus_addr_i == (ADR_MATCH0 + 4'(g)));

    evt_timer_match_unit #(.W(CNT_W)) unit_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_sync_n),
      .val_we_i    (val_we[g]),
      .val_wdata_i (bus_wdata_i[CNT_W-1:0]),
      .act_we_i    (acts_we),
      .act_wdata_i (act_t'(bus_wdata_i[ACT_BITS*g +: ACT_BITS])),
      .flag_clr_i  (flags_we && bus_wdata_i[g]),
      .count_i     (count_q),
      .tick_i      (tick),
      .hit_o       (hit_vec[g]),
      .flag_o      (flag_vec[g]),
      .val_o       (mval[g]),
      .act_o       (acts[g])
    );

    assign act_flat[ACT_BITS*g +: ACT_BITS] = acts[g];
  end

  // combine channel actions
  always_comb begin
    any_halt    = 1'b0;
    any_restart = 1'b0;
    irq         = 1'b0;
    for (int i = 0; i < NUM_MATCH; i++) begin
      any_halt    = any_halt    | (hit_vec[i] & acts[i].halt);
      any_restart = any_restart | (hit_vec[i] & acts[i].restart);
      irq         = irq         | (flag_vec[i] & acts[i].irq_en);
    end
  end

  // control next state: a software write outranks a halting match
  always_comb begin
    ctrl_en = ctrl_we || any_halt;
    run_d   = run_q;
    hold_d  = hold_q;
    if (ctrl_we) begin
      run_d  = bus_wdata_i[0];
      hold_d = bus_wdata_i[1];
    end else if (any_halt) begin
      run_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      run_q  <= 1'b0;
      hold_q <= 1'b0;
    end else if (ctrl_en) begin
      run_q  <= run_d;
      hold_q <= hold_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pre_q <= '0;
    end else if (pre_we) begin
      pre_q <= bus_wdata_i[CNT_W-1:0];
    end
  end

  // counter next state
  always_comb begin
    count_en = hold_q || tick;
    count_d  = count_q;
    if (hold_q) begin
      count_d = '0;
    end else if (tick) begin
      if (any_restart) begin
        count_d = '0;
      end else begin
        count_d = count_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      count_q <= '0;
    end else if (count_en) begin
      count_q <= count_d;
    end
  end

  // combinational read
  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      ADR_CTRL:  bus_rdata_o[1:0]           = {hold_q, run_q};
      ADR_PRE:   bus_rdata_o[CNT_W-1:0]     = pre_q;
      ADR_FLAGS: bus_rdata_o[NUM_MATCH-1:0] = flag_vec;
      ADR_COUNT: bus_rdata_o[CNT_W-1:0]     = count_q;
      ADR_ACTS:  bus_rdata_o[ACT_W-1:0]     = act_flat;
      ADR_PSCNT: bus_rdata_o[CNT_W-1:0]     = pscnt;
      default: begin
        for (int i = 0; i < NUM_MATCH; i++) begin
          if (bus_addr_i == (ADR_MATCH0 + 4'(i))) begin
            bus_rdata_o[CNT_W-1:0] = mval[i];
          end
        end
      end
    endcase
  end

  assign irq_o   = irq;
  assign count_o = count_q;

endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int N = 2,
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] count_q,
  input logic [W-1:0] pscnt,
  input logic         tick,
  input logic         run_q,
  input logic         hold_q,
  input logic [N-1:0] hit_vec,
  input logic [N-1:0] flag_vec,
  input logic         any_halt,
  input logic         ctrl_we,
  input logic         irq_o
);

  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec != '0) |=> ((flag_vec & $past(hit_vec)) == $past(hit_vec)));

  // R3
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |=> (count_q == '0 && pscnt == '0));

  // R8
  halt_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (any_halt && !ctrl_we) |=> !run_q);

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_vec == '0) |-> !irq_o);

  // R2
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !hold_q) |=> $stable(count_q));

  // R4
  tick_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (pscnt == '0));

endmodule

bind evt_match_timer evt_timer_chk #(.N(NUM_MATCH), .W(CNT_W)) chk_i (
  .clk      (clk_i),
  .rst_n    (rst_sync_n),
  .count_q  (count_q),
  .pscnt    (pscnt),
  .tick     (tick),
  .run_q    (run_q),
  .hold_q   (hold_q),
  .hit_vec  (hit_vec),
  .flag_vec (flag_vec),
  .any_halt (any_halt),
  .ctrl_we  (ctrl_we),
  .irq_o    (irq_o)
);

// File: tb/evt_match_timer_tb_top.sv
module evt_match_timer_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;
  localparam int BW = 32;

  localparam logic [3:0] A_CTRL = 4'h0;
  localparam logic [3:0] A_PRE  = 4'h1;
  localparam logic [3:0] A_FLG  = 4'h2;
  localparam logic [3:0] A_CNT  = 4'h3;
  localparam logic [3:0] A_ACT  = 4'h4;
  localparam logic [3:0] A_M0   = 4'h8;
  localparam logic [3:0] A_M1   = 4'h9;

  logic          clk;
  logic          rst_n;
  logic [3:0]    addr;
  logic          we;
  logic [BW-1:0] wdata;
  logic [BW-1:0] rdata;
  logic          irq;
  logic [CW-1:0] count;

  int n_chk;
  int n_err;

  evt_match_timer #(.CNT_W(CW), .BUS_W(BW), .NUM_MATCH(2)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_addr_i  (addr),
    .bus_we_i    (we),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq),
    .count_o     (count)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge with the write applied
  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    addr  = a;
    wdata = d;
    we    = 1'b1;
    @(negedge clk);
    we    = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic setup(input logic [31:0] pre, input logic [31:0] m0,
                       input logic [31:0] m1, input logic [31:0] acts);
    bus_wr(A_CTRL, 32'h2);
    bus_wr(A_FLG, 32'h3);
    bus_wr(A_PRE, pre);
    bus_wr(A_M0, m0);
    bus_wr(A_M1, m1);
    bus_wr(A_ACT, acts);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 count", 32'(count), 0);
    check("R1 irq", 32'(irq), 0);
    bus_rd(A_CTRL, d); check("R1 ctrl", d, 0);
    bus_rd(A_PRE, d);  check("R1 prescale", d, 0);
    bus_rd(A_FLG, d);  check("R1 flags", d, 0);
    bus_rd(A_ACT, d);  check("R1 actions", d, 0);
    bus_rd(A_M0, d);   check("R1 match0", d, 0);
  endtask

  task automatic t_freerun();
    logic [31:0] d;
    setup(0, 32'h7000, 32'h7000, 0);
    bus_wr(A_CTRL, 1);
    wait_clk(7);
    check("R4 p0 count", 32'(count), 7);
    bus_rd(A_CNT, d); check("R4 count readback", d, 7);
    bus_wr(A_CTRL, 0);
    check("R2 stop edge", 32'(count), 8);
    wait_clk(5);
    check("R2 stopped holds", 32'(count), 8);
    bus_wr(A_CNT, 32'h55);
    check("R12 count write ignored", 32'(count), 8);
  endtask

  task automatic t_prescale();
    setup(2, 32'h7000, 32'h7000, 0);
    bus_wr(A_CTRL, 1);
    wait_clk(7);
    check("R4 p2 count at 7", 32'(count), 2);
    wait_clk(4);
    check("R4 p2 count at 11", 32'(count), 3);
  endtask

  task automatic t_hold();
    setup(0, 32'h7000, 32'h7000, 0);
    bus_wr(A_CTRL, 3);
    wait_clk(6);
    check("R3 hold keeps zero", 32'(count), 0);
    bus_wr(A_CTRL, 1);
    wait_clk(3);
    check("R3 resume from zero", 32'(count), 3);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    setup(0, 32'h7000, 4, 0);
    bus_wr(A_CTRL, 1);
    wait_clk(4);
    bus_rd(A_FLG, d); check("R6 flag not yet", d, 0);
    wait_clk(1);
    bus_rd(A_FLG, d); check("R6 ch1 flag set", d, 2);
    check("R9 masked irq low", 32'(irq), 0);
    bus_wr(A_ACT, 32'h8);
    check("R9 enabled irq high", 32'(irq), 1);
    bus_wr(A_FLG, 32'h1);
    bus_rd(A_FLG, d); check("R10 write 0 keeps flag", d, 2);
    bus_wr(A_FLG, 32'h2);
    bus_rd(A_FLG, d); check("R10 flag cleared", d, 0);
    check("R9 irq drops", 32'(irq), 0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    setup(0, 5, 32'h7000, 1);
    bus_wr(A_CTRL, 1);
    wait_clk(5);
    bus_wr(A_FLG, 32'h1);
    bus_rd(A_FLG, d); check("R10 set wins over clear", d, 1);
    check("R10 irq kept", 32'(irq), 1);
    bus_wr(A_FLG, 32'h1);
    bus_rd(A_FLG, d); check("R10 later clear", d, 0);
  endtask

  task automatic t_restart();
    logic [31:0] d;
    setup(0, 3, 32'h7000, 32'h2);
    bus_wr(A_CTRL, 1);
    wait_clk(4);
    check("R7 restart to zero", 32'(count), 0);
    wait_clk(2);
    check("R7 counts again", 32'(count), 2);
    wait_clk(2);
    check("R7 second restart", 32'(count), 0);
    bus_rd(A_FLG, d); check("R6 flag without irq action", d, 1);
    check("R9 no irq without enable", 32'(irq), 0);
  endtask

  task automatic t_halt();
    logic [31:0] d;
    setup(0, 2, 32'h7000, 32'h4);
    bus_wr(A_CTRL, 1);
    wait_clk(3);
    check("R8 final increment", 32'(count), 3);
    bus_rd(A_CTRL, d); check("R8 run cleared", d, 0);
    wait_clk(5);
    check("R8 stays stopped", 32'(count), 3);
  endtask

  task automatic t_write_wins();
    logic [31:0] d;
    setup(0, 2, 32'h7000, 32'h4);
    bus_wr(A_CTRL, 1);
    wait_clk(2);
    bus_wr(A_CTRL, 1);
    bus_rd(A_CTRL, d); check("R11 write kept run", d, 1);
    wait_clk(2);
    check("R11 still counting", 32'(count), 5);
  endtask

  task automatic t_oneshot();
    logic [31:0] d;
    setup(3, 1, 32'h7000, 32'h7);
    bus_wr(A_CTRL, 1);
    wait_clk(7);
    check("R13 before event count", 32'(count), 1);
    check("R13 before event irq", 32'(irq), 0);
    wait_clk(1);
    check("R13 irq at 2(P+1)", 32'(irq), 1);
    check("R13 count back to zero", 32'(count), 0);
    bus_rd(A_CTRL, d); check("R13 stopped", d, 0);
    wait_clk(12);
    check("R13 stays at zero", 32'(count), 0);
    check("R9 level held", 32'(irq), 1);
  endtask

  task automatic t_wrap();
    setup(0, 32'h7000, 32'h7000, 0);
    bus_wr(A_CTRL, 1);
    wait_clk(65535);
    check("R5 all ones", 32'(count), 32'hFFFF);
    wait_clk(1);
    check("R5 wrapped", 32'(count), 0);
    wait_clk(2);
    check("R5 keeps running", 32'(count), 2);
  endtask

  initial begin
    n_chk = 0;
    n_err = 0;
    rst_n = 1'b0;
    we    = 1'b0;
    addr  = '0;
    wdata = '0;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(3);
    t_reset();
    t_freerun();
    t_prescale();
    t_hold();
    t_mask();
    t_collide();
    t_restart();
    t_halt();
    t_write_wins();
    t_oneshot();
    t_wrap();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule